// File: doc/BRIEF.md
# Trigger Combiner with Busy Gating

This block merges several trigger sources into a single accepted trigger and fans it out to eight front-end outputs. Two asynchronous external inputs are synchronized and passed through per-source enables. An internal periodic oscillator and a software trigger level join them. The OR of these gated sources forms the combined trigger. A rising edge of the combined trigger is accepted only while the busy latch is clear. Each accepted edge sets the busy latch and drives a fixed-width pulse to every front-end output whose output enable is set.

Software controls the block through a 32-bit register port addressed by register number. The port exposes:
- source enables and output enables;
- live status levels and sticky catch bits for every stage of the trigger path;
- an accepted-trigger counter and a pre-busy counter, which counts every combined rising edge whether or not busy blocked it;
- the oscillator period;
- the busy latch;
- a command register holding the software trigger level and a self-clearing module reset.

Writes take effect at the clock edge where the write strobe is high. Reads are combinational on the address.

Top module: `trig_combiner`

## Requirements
- R1: Source enable register (address 0) gates the sources: bit 0 gates external input 0, bit 1 gates external input 1, bit 24 gates the oscillator; a disabled source produces no output pulse and no counts.
- R2: Status register (address 1) shows live levels: bits 0/1 the synchronized external inputs, bits 8/9 the same after the enables, bit 16 the combined trigger, bit 17 the output pulse, bit 24 the oscillator; all other bits read 0.
- R3: Catch register (address 2) uses the status layout; a bit becomes 1 on any cycle its signal is high and stays 1; a write keeps only the catch bits whose write-data bit is 1, so writing 0 clears all of them.
- R4: Output enable register (address 3) resets to 0x000000FF; bit n gates front-end output n.
- R5: Each accepted trigger drives enabled outputs high for exactly 2 clock cycles. The pulse starts at the third clock edge after the external input rises.
- R6: Busy (address 7, bit 0) is set by an accepted trigger and blocks further output pulses. Writing address 7 with bit 0 = 0 clears it. Writing bit 0 = 1 leaves it unchanged.
- R7: With oscillator period P (address 6) at 2 or more, the oscillator is high one cycle in every P cycles. Writing the period restarts its count. P = 0 stops it.
- R8: Command register (address 8) bit 0 is a software trigger level that reads back and joins the combined trigger.
- R9: Writing 1 to command bit 1 resets the module state, including enables, period, busy, catch, counters and the command bits, to reset values; the bit reads back 0.
- R10: Address 4 counts accepted triggers and address 5 counts every combined rising edge, including those blocked by busy; any write to either register clears it.
- R11: External inputs pass a two-flop synchronizer. A level held high produces only one trigger.
- R12: Unused addresses read 0; the register map is 0 enables, 1 status, 2 catch, 3 output enables, 4 accepted count, 5 pre-busy count, 6 period, 7 busy, 8 command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_trig_i | input | 2 | Asynchronous external trigger inputs |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register number |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| fe_trig_o | output | 8 | Front-end trigger pulses |

## Verification
A stuck or wrongly set busy latch shows up at the outputs within three cycles of the next source edge. It appears either as a missing pulse or as a second pulse where only one may appear, and the bench counts pulses per output bit to catch both. The bench checks pulse width and start cycle against exact negedge samples, so an off-by-one in the pulse counter or synchronizer depth surfaces at once. Counter, catch and oscillator faults are visible through register reads right after the stimulus, including the 10 edges the pre-busy counter must record over a 50-cycle window at period 5 while only one trigger is accepted.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_SRC_EN  = 5'd0;
  localparam logic [ADDR_W-1:0] A_STATUS  = 5'd1;
  localparam logic [ADDR_W-1:0] A_CATCH   = 5'd2;
  localparam logic [ADDR_W-1:0] A_OUT_EN  = 5'd3;
  localparam logic [ADDR_W-1:0] A_ACC_CNT = 5'd4;
  localparam logic [ADDR_W-1:0] A_RAW_CNT = 5'd5;
  localparam logic [ADDR_W-1:0] A_OSC_PER = 5'd6;
  localparam logic [ADDR_W-1:0] A_BUSY    = 5'd7;
  localparam logic [ADDR_W-1:0] A_CMD     = 5'd8;

  localparam int OSC_EN_BIT = 24;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= async_i[i];
        s2_q <= s1_q;
      end
    end
    assign sync_o[i] = s2_q;
  end
endmodule

// File: rtl/trig_osc.sv
module trig_osc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         restart,
  input  logic [W-1:0] period,
  output logic         pulse_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         hit;

  assign hit     = (period != '0) && (cnt_q == period - 1'b1);
  assign pulse_o = hit;

  always_comb begin
    if (clr || restart || hit || period == '0) cnt_d = '0;
    else                                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: with a period above one, a tick is never followed directly by another
  assert_osc_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && !restart && !clr && period > 1) |=> !pulse_o);
endmodule

// File: rtl/trig_counter.sv
module trig_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_cnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> cnt_o == $past(cnt_o) + 1'b1);
  assert_cnt_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_o == '0);
endmodule

// File: rtl/trig_combiner.sv
module trig_combiner
  import trig_pkg::*;
#(
  parameter int N_FE         = 8,
  parameter int PULSE_CYCLES = 2,
  parameter int CNT_W        = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ext_trig_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic [N_FE-1:0]   fe_trig_o
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);

  // register write decode
  logic wr_en, wr_oen, wr_catch, wr_acc, wr_raw, wr_per, wr_busy, wr_cmd;
  assign wr_en    = reg_wr_i && reg_addr_i == A_SRC_EN;
  assign wr_oen   = reg_wr_i && reg_addr_i == A_OUT_EN;
  assign wr_catch = reg_wr_i && reg_addr_i == A_CATCH;
  assign wr_acc   = reg_wr_i && reg_addr_i == A_ACC_CNT;
  assign wr_raw   = reg_wr_i && reg_addr_i == A_RAW_CNT;
  assign wr_per   = reg_wr_i && reg_addr_i == A_OSC_PER;
  assign wr_busy  = reg_wr_i && reg_addr_i == A_BUSY;
  assign wr_cmd   = reg_wr_i && reg_addr_i == A_CMD;

  // state
  logic [1:0]       en_ext_q, en_ext_d;
  logic             en_osc_q, en_osc_d;
  logic [N_FE-1:0]  oen_q, oen_d;
  logic [REG_W-1:0] period_q, period_d;
  logic [REG_W-1:0] catch_q, catch_d;
  logic             busy_q, busy_d;
  logic             soft_q, soft_d;
  logic             srst_q, srst_d;
  logic             comb_q, comb_d;
  logic [PW-1:0]    pcnt_q, pcnt_d;

  logic             clr;
  logic [1:0]       ext_sync, ext_gated;
  logic             osc_tick, comb, comb_rise, accept, sent;
  logic [REG_W-1:0] stat_vec;
  logic [CNT_W-1:0] acc_cnt, raw_cnt;

  assign clr = srst_q;

  trig_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ext_trig_i), .sync_o(ext_sync)
  );

  trig_osc #(.W(REG_W)) u_osc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .restart(wr_per),
    .period(period_q), .pulse_o(osc_tick)
  );

  assign ext_gated = ext_sync & en_ext_q;
  assign comb      = (|ext_gated) | (osc_tick & en_osc_q) | soft_q;
  assign comb_rise = comb & ~comb_q;
  assign accept    = comb_rise & ~busy_q;
  assign sent      = pcnt_q != '0;

  assign stat_vec = {7'b0, osc_tick, 6'b0, sent, comb, 6'b0, ext_gated, 6'b0, ext_sync};

  trig_counter #(.W(CNT_W)) u_acc_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr | wr_acc), .inc(accept), .cnt_o(acc_cnt)
  );
  trig_counter #(.W(CNT_W)) u_raw_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr | wr_raw), .inc(comb_rise), .cnt_o(raw_cnt)
  );

  // next state
  always_comb begin
    en_ext_d = en_ext_q;
    en_osc_d = en_osc_q;
    oen_d    = oen_q;
    period_d = period_q;
    catch_d  = catch_q;
    busy_d   = busy_q;
    soft_d   = soft_q;
    srst_d   = wr_cmd && reg_wdata_i[1];
    comb_d   = comb;
    pcnt_d   = sent ? pcnt_q - 1'b1 : pcnt_q;
    if (wr_en) begin
      en_ext_d = reg_wdata_i[1:0];
      en_osc_d = reg_wdata_i[OSC_EN_BIT];
    end
    if (wr_oen)   oen_d    = reg_wdata_i[N_FE-1:0];
    if (wr_per)   period_d = reg_wdata_i;
    if (wr_catch) catch_d  = catch_q & reg_wdata_i;
    catch_d = catch_d | stat_vec;
    if (wr_busy && !reg_wdata_i[0]) busy_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      pcnt_d = PW'(PULSE_CYCLES);
    end
    if (wr_cmd) soft_d = reg_wdata_i[0];
    if (clr) begin
      en_ext_d = '0;
      en_osc_d = 1'b0;
      oen_d    = '1;
      period_d = '0;
      catch_d  = '0;
      busy_d   = 1'b0;
      soft_d   = 1'b0;
      comb_d   = 1'b0;
      pcnt_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_ext_q <= '0;
      en_osc_q <= 1'b0;
      oen_q    <= '1;
      period_q <= '0;
      catch_q  <= '0;
      busy_q   <= 1'b0;
      soft_q   <= 1'b0;
      srst_q   <= 1'b0;
      comb_q   <= 1'b0;
      pcnt_q   <= '0;
    end else begin
      en_ext_q <= en_ext_d;
      en_osc_q <= en_osc_d;
      oen_q    <= oen_d;
      period_q <= period_d;
      catch_q  <= catch_d;
      busy_q   <= busy_d;
      soft_q   <= soft_d;
      srst_q   <= srst_d;
      comb_q   <= comb_d;
      pcnt_q   <= pcnt_d;
    end
  end

  assign fe_trig_o = {N_FE{sent}} & oen_q;

  // read mux
  always_comb begin
    case (reg_addr_i)
      A_SRC_EN:  reg_rdata_o = {7'b0, en_osc_q, 22'b0, en_ext_q};
      A_STATUS:  reg_rdata_o = stat_vec;
      A_CATCH:   reg_rdata_o = catch_q;
      A_OUT_EN:  reg_rdata_o = REG_W'(oen_q);
      A_ACC_CNT: reg_rdata_o = REG_W'(acc_cnt);
      A_RAW_CNT: reg_rdata_o = REG_W'(raw_cnt);
      A_OSC_PER: reg_rdata_o = period_q;
      A_BUSY:    reg_rdata_o = {31'b0, busy_q};
      A_CMD:     reg_rdata_o = {31'b0, soft_q};
      default:   reg_rdata_o = '0;
    endcase
  end

  // busy holds until software clears it (R6)
  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !(wr_busy && !reg_wdata_i[0]) && !clr) |=> busy_q);
  assert_busy_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !clr) |=> busy_q);
  // output pulse only starts from an accepted edge and lasts past its first cycle (R5)
  assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sent) |-> $past(accept));
  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sent) && !clr) |=> sent);
  // every status level seen is captured (R3)
  assert_catch_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((catch_q & $past(stat_vec)) == $past(stat_vec)));
endmodule

// File: tb/trig_combiner_tb.sv
module trig_combiner_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ext = '0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  fe;

  int checks = 0;
  int fails  = 0;

  trig_combiner dut_i (
    .clk(clk), .rst_n(rst_n), .ext_trig_i(ext), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .fe_trig_o(fe)
  );

  always #10 clk = ~clk;

  // pulse monitor
  logic     mon_clr = 1'b0;
  int       hi_cnt [8];
  int       rise_cnt [8];
  logic [7:0] fe_prev = '0;
  always @(negedge clk) begin
    for (int i = 0; i < 8; i++) begin
      if (mon_clr) begin
        hi_cnt[i] = 0; rise_cnt[i] = 0;
      end else if (fe[i]) begin
        hi_cnt[i]++;
        if (!fe_prev[i]) rise_cnt[i]++;
      end
    end
    fe_prev = fe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic mclear();
    @(negedge clk); mon_clr = 1'b1; @(negedge clk); mon_clr = 1'b0;
  endtask

  function automatic logic [7:0] rise_mask();
    logic [7:0] m = '0;
    for (int i = 0; i < 8; i++) m[i] = rise_cnt[i] != 0;
    return m;
  endfunction

  task automatic pulse_ext(input logic [1:0] v, input int hold);
    @(negedge clk); ext = v;
    repeat (hold) @(negedge clk);
    ext = '0;
    repeat (8) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0] ext;
    logic [1:0] en;
    logic [7:0] oen;
    logic [7:0] exp_fe;
    logic       exp_acc;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'b01, 2'b01, 8'hFF, 8'hFF, 1'b1},
    '{2'b01, 2'b10, 8'hFF, 8'h00, 1'b0},
    '{2'b10, 2'b10, 8'h0F, 8'h0F, 1'b1},
    '{2'b11, 2'b11, 8'hA5, 8'hA5, 1'b1},
    '{2'b10, 2'b01, 8'hFF, 8'h00, 1'b0},
    '{2'b11, 2'b10, 8'h80, 8'h80, 1'b1}
  };

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R4 reset fe", {24'b0, fe}, 32'h0);
    rreg(5'd3, d); chk("R4 reset out enable", d, 32'hFF);
    rreg(5'd0, d); chk("R1 reset src enable", d, 32'h0);
    rreg(5'd7, d); chk("R6 reset busy", d, 32'h0);
    rreg(5'd4, d); chk("R10 reset acc count", d, 32'h0);
    rreg(5'd5, d); chk("R10 reset raw count", d, 32'h0);
    rreg(5'd20, d); chk("R12 unused address", d, 32'h0);

    // table-driven gating
    foreach (VECS[k]) begin
      wreg(5'd0, {30'b0, VECS[k].en});
      wreg(5'd3, {24'b0, VECS[k].oen});
      wreg(5'd7, 32'h0);
      wreg(5'd4, 32'h0);
      mclear();
      pulse_ext(VECS[k].ext, 4);
      chk("R1 R4 output mask", {24'b0, rise_mask()}, {24'b0, VECS[k].exp_fe});
      for (int i = 0; i < 8; i++)
        if (VECS[k].exp_fe[i]) chk("R5 pulse width", hi_cnt[i], 2);
      rreg(5'd4, d); chk("R10 acc count per vector", d, {31'b0, VECS[k].exp_acc});
    end

    // exact latency
    wreg(5'd0, 32'h1); wreg(5'd3, 32'hFF); wreg(5'd7, 32'h0);
    @(negedge clk); ext = 2'b01;
    @(negedge clk); chk("R5 latency c1", {24'b0, fe}, 32'h0);
    @(negedge clk); chk("R5 latency c2", {24'b0, fe}, 32'h0);
    @(negedge clk); chk("R5 latency c3", {24'b0, fe}, 32'hFF);
    @(negedge clk); chk("R5 latency c4", {24'b0, fe}, 32'hFF);
    @(negedge clk); chk("R5 latency c5", {24'b0, fe}, 32'h0);
    ext = '0; repeat (6) @(negedge clk);

    // busy blocking, pre-busy counting
    wreg(5'd7, 32'h0); wreg(5'd4, 32'h0); wreg(5'd5, 32'h0);
    mclear();
    pulse_ext(2'b01, 3);
    pulse_ext(2'b01, 3);
    chk("R6 busy blocks second pulse", rise_cnt[0], 1);
    rreg(5'd4, d); chk("R10 acc count while busy", d, 32'd1);
    rreg(5'd5, d); chk("R10 raw count while busy", d, 32'd2);
    rreg(5'd7, d); chk("R6 busy set", d, 32'h1);
    wreg(5'd7, 32'h1);
    rreg(5'd7, d); chk("R6 write one keeps busy", d, 32'h1);
    wreg(5'd7, 32'h0);
    rreg(5'd7, d); chk("R6 write zero clears busy", d, 32'h0);
    mclear();
    pulse_ext(2'b01, 3);
    chk("R6 fires after clear", rise_cnt[0], 1);

    // held level, single trigger
    wreg(5'd7, 32'h0); mclear();
    pulse_ext(2'b01, 20);
    chk("R11 held level one trigger", rise_cnt[0], 1);

    // status
    wreg(5'd0, 32'h2);
    @(negedge clk); ext = 2'b10;
    repeat (8) @(negedge clk);
    rreg(5'd1, d); chk("R2 status ext1 held", d, 32'h0001_0202);
    ext = 2'b11; repeat (3) @(negedge clk);
    rreg(5'd1, d); chk("R2 status ext0 ungated", d, 32'h0001_0203);
    ext = '0; repeat (4) @(negedge clk);

    // catch
    wreg(5'd0, 32'h0); wreg(5'd2, 32'h0);
    rreg(5'd2, d); chk("R3 catch cleared", d, 32'h0);
    pulse_ext(2'b01, 3);
    rreg(5'd2, d); chk("R3 catch ungated input", d, 32'h1);
    wreg(5'd2, 32'hFFFF_FFFF);
    rreg(5'd2, d); chk("R3 catch kept by ones", d, 32'h1);
    wreg(5'd2, 32'h0);
    rreg(5'd2, d); chk("R3 catch cleared by zero", d, 32'h0);
    wreg(5'd0, 32'h1); wreg(5'd7, 32'h0);
    pulse_ext(2'b01, 3);
    rreg(5'd2, d); chk("R3 catch full path", d, 32'h0003_0101);

    // oscillator
    wreg(5'd0, 32'h0);
    wreg(5'd6, 32'd5); wreg(5'd5, 32'h0); wreg(5'd4, 32'h0); wreg(5'd7, 32'h0);
    wreg(5'd0, 32'h0100_0000);
    repeat (48) @(negedge clk);
    wreg(5'd0, 32'h0);
    rreg(5'd5, d); chk("R7 osc ticks in 50 cycles", d, 32'd10);
    rreg(5'd4, d); chk("R7 osc accepted once", d, 32'd1);
    wreg(5'd6, 32'd0); wreg(5'd5, 32'h0); wreg(5'd0, 32'h0100_0000);
    repeat (20) @(negedge clk);
    rreg(5'd5, d); chk("R7 period zero stops", d, 32'd0);
    wreg(5'd0, 32'h0);

    // soft trigger
    wreg(5'd7, 32'h0); wreg(5'd4, 32'h0); mclear();
    wreg(5'd8, 32'h1);
    repeat (5) @(negedge clk);
    rreg(5'd8, d); chk("R8 soft level reads back", d, 32'h1);
    rreg(5'd4, d); chk("R8 soft trigger accepted", d, 32'd1);
    chk("R8 soft trigger pulse", {24'b0, rise_mask()}, 32'hFF);
    wreg(5'd8, 32'h0);
    rreg(5'd8, d); chk("R8 soft level cleared", d, 32'h0);

    // module reset
    wreg(5'd0, 32'h3); wreg(5'd3, 32'h12); wreg(5'd6, 32'd7);
    wreg(5'd8, 32'h1);
    repeat (4) @(negedge clk);
    wreg(5'd8, 32'h2);
    repeat (3) @(negedge clk);
    rreg(5'd3, d); chk("R9 out enable restored", d, 32'hFF);
    rreg(5'd0, d); chk("R9 src enable cleared", d, 32'h0);
    rreg(5'd6, d); chk("R9 period cleared", d, 32'h0);
    rreg(5'd7, d); chk("R9 busy cleared", d, 32'h0);
    rreg(5'd4, d); chk("R9 acc count cleared", d, 32'h0);
    rreg(5'd5, d); chk("R9 raw count cleared", d, 32'h0);
    rreg(5'd2, d); chk("R9 catch cleared", d, 32'h0);
    rreg(5'd8, d); chk("R9 command reads zero", d, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule